// File: doc/BRIEF.md
# Receive FIFO Interrupt Controller

This block sits between a contactless receiver's byte output and a host microcontroller. Received bytes go into a 128-entry FIFO. Strobes mark start of frame, end of frame, framing errors and CRC errors, and these strobes set cause bits in an interrupt status register. The interrupt output stays high while any cause bit is set.

A programmable level decides how the host is told about incoming data. If a frame holds no more bytes than the level, the host gets only a completion cause at end of frame. If a frame holds more, a level cause fires while the frame is still arriving, so the host can drain bytes early. The level cause fires again each time the host brings the count back to or below the level and the count then climbs past it.

The host uses a small register port with combinational read data. Reading the status register returns the causes and clears them. Reading the data address pops one byte. A FIFO status register reports how many bytes are waiting.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset, the status register (address 0x0C) reads 0, the FIFO status register (address 0x1C) reads 0, the level register (address 0x14) reads 8, and irq_o is low.
- R2: A start-of-frame strobe sets status bit 6, and irq_o is high after the next clock edge.
- R3: A frame whose byte count never exceeds the level leaves status bit 5 clear. Its end-of-frame strobe sets status bit 7.
- R4: During a frame, once the FIFO count exceeds the level, status bit 5 is set. It is visible in the cycle after the byte that crossed the level.
- R5: After the level cause fires, it does not fire again until the count has returned to or below the level. It fires again when the count next exceeds the level within the frame.
- R6: Address 0x1C reads the number of stored bytes. Each read of address 0x1F returns the oldest byte and removes it. A read of 0x1F on an empty FIFO returns 0 and changes nothing.
- R7: A read of address 0x0C returns the status and clears every bit. irq_o goes low unless a new cause arrives in that cycle.
- R8: A framing-error strobe sets status bit 3 and a CRC-error strobe sets status bit 4.
- R9: A byte that arrives while 128 bytes are stored, with no pop in the same cycle, is dropped and sets status bit 2. The count stays 128.
- R10: A start-of-frame strobe empties the FIFO and clears status bits 2, 3 and 4.
- R11: A write to address 0x14 sets the 8-bit level, and a read of 0x14 returns it.
- R12: A cause that arrives in the same cycle as a status read is kept, not lost to the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | Start-of-frame strobe |
| rx_eof_i | input | 1 | End-of-frame strobe |
| rx_frm_err_i | input | 1 | Framing error strobe |
| rx_crc_err_i | input | 1 | CRC error strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_rd_i | input | 1 | Register read enable (clears status at 0x0C, pops at 0x1F) |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The assertions check, on every cycle:
- start-of-frame, end-of-frame and CRC-error strobes always raise the interrupt on the next edge;
- the stored count never exceeds the depth;
- the count holds when no byte arrives, no frame starts and no pop is made;
- a byte offered to a full FIFO sets the overflow cause.

Only the bench scenarios can show the rest:
- the choice between the level cause and completion alone;
- re-arming the level cause after the host drains bytes;
- first-in-first-out byte order;
- clearing of errors by a new frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned AW_REG = 5;
  localparam logic [AW_REG-1:0] ADDR_STAT  = 5'h0C;
  localparam logic [AW_REG-1:0] ADDR_LEVEL = 5'h14;
  localparam logic [AW_REG-1:0] ADDR_FSTAT = 5'h1C;
  localparam logic [AW_REG-1:0] ADDR_DATA  = 5'h1F;

  localparam int unsigned B_DONE = 7;
  localparam int unsigned B_SOF  = 6;
  localparam int unsigned B_LVL  = 5;
  localparam int unsigned B_CRC  = 4;
  localparam int unsigned B_FRM  = 3;
  localparam int unsigned B_OVF  = 2;

  localparam logic [7:0] ERR_MASK = 8'h1C;
endpackage

// File: rtl/rxf_byte_fifo.sv
module rxf_byte_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          empty, full, do_pop, do_push;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign drop_o  = push_i && !flush_i && full && !pop_i;
  assign head_o  = mem[rd_ptr];
  assign count_o = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= push_i ? AW'(1) : '0;
      cnt    <= push_i ? CW'(1) : '0;
    end else begin
      if (do_push) wr_ptr <= inc(wr_ptr);
      if (do_pop)  rd_ptr <= inc(rd_ptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (flush_i && push_i) mem[0] <= data_i;
    else if (!flush_i && do_push) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/rxf_level_trig.sv
module rxf_level_trig #(
  parameter int unsigned CW = 8,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rearm_i,
  input  logic          active_i,
  input  logic [CW-1:0] count_i,
  input  logic [LW-1:0] level_i,
  output logic          fire_o
);
  logic armed, above;

  assign above  = int'(count_i) > int'(level_i);
  assign fire_o = armed && active_i && above;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed <= 1'b1;
    else if (rearm_i) armed <= 1'b1;
    else if (fire_o)  armed <= 1'b0;
    else if (!above)  armed <= 1'b1;
  end
endmodule

// File: rtl/rxf_stat_reg.sv
module rxf_stat_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter logic [7:0]  LEVEL_RST = 8'd8,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_sof_i,
  input  logic       rx_eof_i,
  input  logic       rx_frm_err_i,
  input  logic       rx_crc_err_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [4:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  logic [7:0]    level_q, stat, set_v, clr_v, head;
  logic [CW-1:0] count;
  logic          in_frame, lvl_fire, drop, pop, rd_stat;

  assign pop     = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign rd_stat = reg_rd_i && (reg_addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= LEVEL_RST;
      in_frame <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == ADDR_LEVEL) level_q <= reg_wdata_i;
      if (rx_sof_i)      in_frame <= 1'b1;
      else if (rx_eof_i) in_frame <= 1'b0;
    end
  end

  rxf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_sof_i),
    .push_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .pop_i   (pop && !rx_sof_i),
    .head_o  (head),
    .count_o (count),
    .drop_o  (drop)
  );

  rxf_level_trig #(.CW(CW), .LW(8)) u_lvl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rearm_i  (rx_sof_i),
    .active_i (in_frame),
    .count_i  (count),
    .level_i  (level_q),
    .fire_o   (lvl_fire)
  );

  always_comb begin
    set_v = '0;
    set_v[B_DONE] = rx_eof_i;
    set_v[B_SOF]  = rx_sof_i;
    set_v[B_LVL]  = lvl_fire;
    set_v[B_CRC]  = rx_crc_err_i;
    set_v[B_FRM]  = rx_frm_err_i;
    set_v[B_OVF]  = drop;
    clr_v = (rd_stat ? 8'hFF : 8'h00) | (rx_sof_i ? ERR_MASK : 8'h00);
  end

  rxf_stat_reg #(.W(8)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .stat_o (stat)
  );

  assign irq_o = |stat;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_STAT:  reg_rdata_o = stat;
      ADDR_LEVEL: reg_rdata_o = level_q;
      ADDR_FSTAT: reg_rdata_o = 8'(count);
      ADDR_DATA:  reg_rdata_o = (count != '0) ? head : 8'h00;
      default:    reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          rx_sof_i,
  input logic          rx_eof_i,
  input logic          rx_crc_err_i,
  input logic          reg_rd_i,
  input logic [4:0]    reg_addr_i,
  input logic [CW-1:0] count,
  input logic [7:0]    stat,
  input logic          irq_o
);
  logic data_rd;
  assign data_rd = reg_rd_i && (reg_addr_i == 5'h1F);

  assert_sof_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sof_i |=> (irq_o && stat[6]));

  assert_eof_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_eof_i |=> stat[7]);

  assert_crc_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_crc_err_i |=> stat[4]);

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count) <= int'(DEPTH));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count) == int'(DEPTH) && rx_valid_i && !rx_sof_i && !data_rd) |=> stat[2]);

  assert_count_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid_i && !rx_sof_i && !data_rd) |=> $stable(count));
endmodule

bind rx_fifo_irq rx_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_sof_i     (rx_sof_i),
  .rx_eof_i     (rx_eof_i),
  .rx_crc_err_i (rx_crc_err_i),
  .reg_rd_i     (reg_rd_i),
  .reg_addr_i   (reg_addr_i),
  .count        (count),
  .stat         (stat),
  .irq_o        (irq_o)
);

// File: tb/tb_rx_fifo_irq.sv
module tb_rx_fifo_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rx_valid = 0, rx_sof = 0, rx_eof = 0, frm_err = 0, crc_err = 0;
  logic [7:0] rx_data = 0, wdata = 0, rdata;
  logic       reg_wr = 0, reg_rd = 0, irq;
  logic [4:0] addr = 0;

  int checks = 0, errors = 0, model_cnt = 0;
  logic [7:0] exp_q [$];
  logic [7:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_frm_err_i(frm_err),
    .rx_crc_err_i(crc_err), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; addr = a; #1 d = rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; addr = a; wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  // driver: pushes the expected byte into the scoreboard when it is accepted
  task automatic send(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    if (model_cnt < 128) begin exp_q.push_back(d); model_cnt++; end
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic pulse_sof();
    @(negedge clk); rx_sof = 1; exp_q.delete(); model_cnt = 0;
    @(negedge clk); rx_sof = 0;
  endtask

  task automatic pulse_eof();
    @(negedge clk); rx_eof = 1; @(negedge clk); rx_eof = 0;
  endtask

  // monitor: pops from the scoreboard and compares with read data
  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rd(5'h1F, v);
      if (exp_q.size() > 0) begin
        check(req, v, exp_q.pop_front());
        model_cnt--;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", irq, 0);
    rd(5'h0C, v); check("R1 status", v, 0);
    rd(5'h1C, v); check("R1 fifo status", v, 0);
    rd(5'h14, v); check("R1 level", v, 8);
    // R11 level register
    wr(5'h14, 8'd4); rd(5'h14, v); check("R11 level", v, 4);

    // R2 / R7 start of frame, then read-clear
    pulse_sof(); check("R2 irq", irq, 1);
    rd(5'h0C, v); check("R2 sof bit", v, 8'h40);
    check("R7 irq cleared", irq, 0);
    rd(5'h0C, v); check("R7 status cleared", v, 0);

    // R3 short frame: 4 bytes with level 4
    for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i));
    rd(5'h0C, v); check("R3 no level cause", v, 0);
    pulse_eof(); rd(5'h0C, v); check("R3 done only", v, 8'h80);
    rd(5'h1C, v); check("R6 count", v, 4);
    drain(4, "R6 order");
    rd(5'h1F, v); check("R6 empty read", v, 0);
    rd(5'h1C, v); check("R6 empty count", v, 0);

    // R4 / R5 long frame
    pulse_sof(); rd(5'h0C, v);
    for (int i = 0; i < 5; i++) send(8'h10 + 8'(i));
    rd(5'h0C, v); check("R4 level cause", v, 8'h20);
    for (int i = 0; i < 3; i++) send(8'h20 + 8'(i));
    rd(5'h0C, v); check("R5 no refire while above", v, 0);
    drain(5, "R6 order");
    rd(5'h1C, v); check("R6 count after pops", v, 3);
    send(8'h30); send(8'h31);
    rd(5'h0C, v); check("R5 refire", v, 8'h20);
    pulse_eof(); rd(5'h0C, v); check("R3 done long", v, 8'h80);
    drain(5, "R6 order");

    // R8 errors, R10 sof clears them and the fifo
    pulse_sof(); send(8'h55); send(8'h66);
    @(negedge clk); frm_err = 1; @(negedge clk); frm_err = 0;
    @(negedge clk); crc_err = 1; @(negedge clk); crc_err = 0;
    rd(5'h0C, v); check("R8 error bits", v, 8'h58);
    @(negedge clk); frm_err = 1; @(negedge clk); frm_err = 0;
    pulse_sof();
    rd(5'h0C, v); check("R10 errors cleared", v, 8'h40);
    rd(5'h1C, v); check("R10 count cleared", v, 0);

    // R9 overflow
    for (int i = 0; i < 129; i++) send(8'(i * 3 + 1));
    rd(5'h1C, v); check("R9 count full", v, 128);
    rd(5'h0C, v); check("R9 overflow", v, 8'h24);
    drain(128, "R9 order");
    pulse_sof(); rd(5'h0C, v);

    // R12 cause in the same cycle as a status read
    @(negedge clk); reg_rd = 1; addr = 5'h0C; rx_sof = 1;
    @(negedge clk); reg_rd = 0; rx_sof = 0;
    check("R12 irq kept", irq, 1);
    rd(5'h0C, v); check("R12 sof kept", v, 8'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule